// File: doc/BRIEF.md
# Match-Action Timer

This block is a general-purpose timer. A free-running prescaler divides the system clock, and a 16-bit counter advances once each time the prescaler wraps. The counter runs in one of three directions: up, down, or up-then-down between zero and a top value. Ten compare registers are checked against the counter on every counter step. The highest-numbered compare register also serves as the top value in up-then-down mode and as the reload value in down mode.

Each compare channel owns three action bits: raise an interrupt flag, restart the counter, and halt the timer. A halt freezes both the counter and the prescaler, and it clears the run bit so that software can see the timer has stopped. The action bits sit in two control words. Writes to these words only land when the top byte of the written data carries a fixed key, which guards them against stray writes.

Software reaches every register through a plain synchronous register port: write strobe, word address, write data and registered read data. The block drives out the run bit, a combined interrupt line, the per-channel interrupt flags and a per-channel match pulse.

Top module: `match_timer`

## Requirements
- R1: After a synchronous reset the run bit, mode (0 = up), prescale value, counter, prescaler count, all action bits, interrupt flags, match pulses and read data are zero.
- R2: While running with prescale value P, the prescaler counts 0..P and the counter takes one step on each cycle in which the prescaler count is at least P. Writing the counter (word 2) also clears the prescaler count.
- R3: Action bits for channel n (0..7) are in word 4 and for channel n (8..9) in word 5, at offset k = 3·(n mod 8): bit k enables the interrupt, bit k+1 enables restart, and bit k+2 enables halt.
- R4: A write to word 4 or 5 takes effect only if data bits 31:24 equal 0x5A. Bits 31:24 always read as 0.
- R5: A step in which compare n equals the counter, with its interrupt bit set, sets flag n (read at word 6). Writing 1 to a bit of word 6 clears that flag, and a set in the same cycle wins. `irq` is the OR of the flags.
- R6: In up mode (mode 0, or the unused code 3) a step adds 1. A step where a channel with restart set matches sets the counter to 0.
- R7: A step where a channel with halt set matches leaves the counter and prescaler unchanged and clears the run bit. Halt takes priority over restart and over a run-bit write in the same cycle.
- R8: In down mode (mode 1) a step subtracts 1, wrapping below zero. A restart loads the value of compare register 9 instead of 0.
- R9: In up-then-down mode (mode 2) the counter climbs to compare register 9, turns, and descends to 0, then turns again. Writing word 0 sets the direction to up, and so does a restart, which loads 0.
- R10: `match_stat[n]` is high for exactly the cycle after a step in which compare n equalled the counter, whatever its action bits are.
- R11: While the run bit is 0 the counter and prescaler hold, and no compare is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address: 0 control {mode[2:1], run[0]}, 1 prescale, 2 counter, 3 prescaler count, 4/5 action words, 6 flags, 16+n compare n |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address presented in the previous cycle |
| run | output | 1 | Run bit |
| irq | output | 1 | OR of all interrupt flags |
| irq_flags | output | 10 | Per-channel interrupt flags |
| match_stat | output | 10 | Per-channel one-cycle match pulse |

## Verification
Every effect of a step (counter value, cleared run bit, new flags, match pulse and `irq`) becomes visible at the same clock edge that performs the step. Register writes take effect at their own edge. Read data always shows the state just before the edge at which the address was sampled, so a read is due one cycle after the address is presented. The bench keeps a cycle model that applies these rules, drives inputs and samples outputs at the falling edge, and compares every output once per cycle. Directed runs read the counter on consecutive cycles and compare the values against step sequences worked out by hand.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSVD   = 2'd3
  } cnt_mode_e;

  localparam logic [7:0] ACT_KEY     = 8'h5A;
  localparam int         CH_PER_WORD = 8;

  localparam int A_CTRL     = 0;
  localparam int A_PRESCALE = 1;
  localparam int A_COUNT    = 2;
  localparam int A_PRECOUNT = 3;
  localparam int A_ACT_LO   = 4;
  localparam int A_ACT_HI   = 5;
  localparam int A_FLAGS    = 6;
  localparam int A_CMP_BASE = 16;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             halt,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic [PRE_W-1:0] pre_cnt,
  output logic             tick
);
  assign tick = run && (pre_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else begin
      if (run) begin
        if (!tick)     pre_cnt <= pre_cnt + 1'b1;
        else if (!halt) pre_cnt <= '0;
      end
      if (clr) pre_cnt <= '0;
    end
  end
endmodule

// File: rtl/mt_cmp_bank.sv
module mt_cmp_bank #(
  parameter int N = 10,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic [W-1:0]        wval,
  input  logic [W-1:0]        count,
  input  logic                tick,
  output logic [N-1:0][W-1:0] cmp_val,
  output logic [N-1:0]        hit
);
  logic [W-1:0] cmp_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)        cmp_q[g] <= '0;
      else if (we[g]) cmp_q[g] <= wval;
    end
    assign cmp_val[g] = cmp_q[g];
    assign hit[g]     = tick && (cmp_q[g] == count);
  end
endmodule

// File: rtl/mt_count_unit.sv
module mt_count_unit
  import mt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      halt,
  input  logic      restart,
  input  cnt_mode_e mode,
  input  logic [W-1:0] top,
  input  logic      load,
  input  logic [W-1:0] load_val,
  input  logic      dir_clr,
  output logic [W-1:0] count
);
  logic         up_q;
  logic [W-1:0] adv;
  logic         adv_up;

  always_comb begin
    adv    = count;
    adv_up = up_q;
    case (mode)
      MODE_DOWN: adv = count - 1'b1;
      MODE_CENTER: begin
        if (up_q) begin
          if (count >= top) begin
            if (count != '0) begin
              adv    = count - 1'b1;
              adv_up = 1'b0;
            end
          end else begin
            adv = count + 1'b1;
          end
        end else begin
          if (count == '0) begin
            if (top != '0) begin
              adv    = count + 1'b1;
              adv_up = 1'b1;
            end
          end else begin
            adv = count - 1'b1;
          end
        end
      end
      default: adv = count + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      up_q  <= 1'b1;
    end else begin
      if (tick && !halt) begin
        if (restart) begin
          count <= (mode == MODE_DOWN) ? top : '0;
          up_q  <= 1'b1;
        end else begin
          count <= adv;
          up_q  <= adv_up;
        end
      end
      if (load)    count <= load_val;
      if (dir_clr) up_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 16,
  parameter int N_MATCH = 10,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               run,
  output logic               irq,
  output logic [N_MATCH-1:0] irq_flags,
  output logic [N_MATCH-1:0] match_stat
);
  localparam int ACT_W  = 3 * N_MATCH;
  localparam int LO_W   = 3 * CH_PER_WORD;
  localparam int HI_W   = ACT_W - LO_W;
  localparam int TOP_CH = N_MATCH - 1;

  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_PRE   = ADDR_W'(A_PRESCALE);
  localparam logic [ADDR_W-1:0] AD_CNT   = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_PCNT  = ADDR_W'(A_PRECOUNT);
  localparam logic [ADDR_W-1:0] AD_LO    = ADDR_W'(A_ACT_LO);
  localparam logic [ADDR_W-1:0] AD_HI    = ADDR_W'(A_ACT_HI);
  localparam logic [ADDR_W-1:0] AD_FLAGS = ADDR_W'(A_FLAGS);

  cnt_mode_e                  mode;
  logic [PRE_W-1:0]           presc;
  logic [PRE_W-1:0]           pre_cnt;
  logic [ACT_W-1:0]           act;
  logic                       tick;
  logic [CNT_W-1:0]           count;
  logic [N_MATCH-1:0][CNT_W-1:0] cmp_val;
  logic [N_MATCH-1:0]         hit, ie_m, rs_m, st_m, cmp_we, set_vec, flags_nxt;
  logic                       stop_any, restart_any, key_ok;
  logic                       wr_ctrl, wr_pre, wr_cnt, wr_lo, wr_hi, wr_flags;
  logic [31:0]                rd_mux;

  assign wr_ctrl  = wr_en && (addr == AD_CTRL);
  assign wr_pre   = wr_en && (addr == AD_PRE);
  assign wr_cnt   = wr_en && (addr == AD_CNT);
  assign wr_lo    = wr_en && (addr == AD_LO);
  assign wr_hi    = wr_en && (addr == AD_HI);
  assign wr_flags = wr_en && (addr == AD_FLAGS);
  assign key_ok   = (wdata[31:24] == ACT_KEY);

  for (genvar g = 0; g < N_MATCH; g++) begin : g_act
    assign ie_m[g]   = act[3*g];
    assign rs_m[g]   = act[3*g+1];
    assign st_m[g]   = act[3*g+2];
    assign cmp_we[g] = wr_en && (addr == ADDR_W'(A_CMP_BASE + g));
  end

  assign stop_any    = |(hit & st_m);
  assign restart_any = |(hit & rs_m);
  assign set_vec     = hit & ie_m;
  assign flags_nxt   = (irq_flags & ~(wr_flags ? wdata[N_MATCH-1:0] : '0)) | set_vec;

  mt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .halt(stop_any), .clr(wr_cnt),
    .limit(presc), .pre_cnt(pre_cnt), .tick(tick)
  );

  mt_cmp_bank #(.N(N_MATCH), .W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .we(cmp_we), .wval(wdata[CNT_W-1:0]),
    .count(count), .tick(tick), .cmp_val(cmp_val), .hit(hit)
  );

  mt_count_unit #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .halt(stop_any), .restart(restart_any),
    .mode(mode), .top(cmp_val[TOP_CH]), .load(wr_cnt),
    .load_val(wdata[CNT_W-1:0]), .dir_clr(wr_ctrl), .count(count)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      AD_CTRL:  rd_mux[2:0]       = {mode, run};
      AD_PRE:   rd_mux[PRE_W-1:0] = presc;
      AD_CNT:   rd_mux[CNT_W-1:0] = count;
      AD_PCNT:  rd_mux[PRE_W-1:0] = pre_cnt;
      AD_LO:    rd_mux[LO_W-1:0]  = act[LO_W-1:0];
      AD_HI:    rd_mux[HI_W-1:0]  = act[ACT_W-1:LO_W];
      AD_FLAGS: rd_mux[N_MATCH-1:0] = irq_flags;
      default: begin
        for (int n = 0; n < N_MATCH; n++) begin
          if (addr == ADDR_W'(A_CMP_BASE + n)) rd_mux[CNT_W-1:0] = cmp_val[n];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      mode       <= MODE_UP;
      presc      <= '0;
      act        <= '0;
      irq_flags  <= '0;
      irq        <= 1'b0;
      match_stat <= '0;
      rdata      <= '0;
    end else begin
      if (wr_ctrl) begin
        run  <= wdata[0];
        mode <= cnt_mode_e'(wdata[2:1]);
      end
      if (stop_any) run <= 1'b0;
      if (wr_pre) presc <= wdata[PRE_W-1:0];
      if (wr_lo && key_ok) act[LO_W-1:0]     <= wdata[LO_W-1:0];
      if (wr_hi && key_ok) act[ACT_W-1:LO_W] <= wdata[HI_W-1:0];
      irq_flags  <= flags_nxt;
      irq        <= |flags_nxt;
      match_stat <= hit;
      rdata      <= rd_mux;
    end
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int N     = 10,
  parameter int W     = 16,
  parameter int AW    = 5,
  parameter int ACT_W = 30
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          run,
  input logic          tick,
  input logic          stop_any,
  input logic [W-1:0]  count,
  input logic [ACT_W-1:0] act,
  input logic [N-1:0]  irq_flags,
  input logic [N-1:0]  set_vec,
  input logic [N-1:0]  match_stat
);
  logic cnt_wr, act_wr_nokey;
  assign cnt_wr       = wr_en && (addr == AW'(A_COUNT));
  assign act_wr_nokey = wr_en && ((addr == AW'(A_ACT_LO)) || (addr == AW'(A_ACT_HI)))
                        && (wdata[31:24] != ACT_KEY);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!run && count == '0 && act == '0 && irq_flags == '0));

  p_key_guard_r4: assert property (@(posedge clk) disable iff (rst)
    act_wr_nokey |=> $stable(act));

  p_flag_source_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irq_flags & ~$past(irq_flags) & ~$past(set_vec)) == '0));

  p_halt_clears_run_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && stop_any) |=> !run);

  p_halt_freezes_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && stop_any && !cnt_wr) |=> $stable(count));

  p_pulse_needs_step_r10: assert property (@(posedge clk) disable iff (rst)
    (|match_stat) |-> $past(tick));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

bind match_timer mt_checker #(.N(N_MATCH), .W(CNT_W), .AW(ADDR_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .run(run),
  .tick(tick), .stop_any(stop_any), .count(count), .act(act),
  .irq_flags(irq_flags), .set_vec(set_vec), .match_stat(match_stat)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  import mt_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        run, irq;
  logic [9:0]  irq_flags, match_stat;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .run(run), .irq(irq), .irq_flags(irq_flags), .match_stat(match_stat)
  );

  // bench model state
  logic        m_run, m_up, m_irq;
  logic [1:0]  m_mode;
  logic [15:0] m_presc, m_pc, m_cnt;
  logic [29:0] m_act;
  logic [9:0]  m_flags, m_stat;
  logic [15:0] m_cmp [10];
  logic [31:0] m_rd;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] f_read(input logic [4:0] a);
    logic [31:0] r = '0;
    case (a)
      5'd0: r[2:0]  = {m_mode, m_run};
      5'd1: r[15:0] = m_presc;
      5'd2: r[15:0] = m_cnt;
      5'd3: r[15:0] = m_pc;
      5'd4: r[23:0] = m_act[23:0];
      5'd5: r[5:0]  = m_act[29:24];
      5'd6: r[9:0]  = m_flags;
      default: if (a >= 5'd16 && a <= 5'd25) r[15:0] = m_cmp[a - 5'd16];
    endcase
    return r;
  endfunction

  // returns {direction_up, next_count}
  function automatic logic [16:0] f_adv(input logic [1:0] md, input logic [15:0] c,
                                        input logic [15:0] top, input logic up);
    logic [15:0] n = c;
    logic        u = up;
    if (md == 2'd1) n = c - 16'd1;
    else if (md == 2'd2) begin
      if (up) begin
        if (c >= top) begin
          if (c != 0) begin n = c - 16'd1; u = 1'b0; end
        end else n = c + 16'd1;
      end else begin
        if (c == 0) begin
          if (top != 0) begin n = c + 16'd1; u = 1'b1; end
        end else n = c - 16'd1;
      end
    end else n = c + 16'd1;
    return {u, n};
  endfunction

  task automatic step(input logic w, input logic [4:0] a, input logic [31:0] d);
    logic        tk, stp, rld, ncen, nup;
    logic [9:0]  hit, ie, rs, st, nfl;
    logic [15:0] ncnt, npc;
    logic [1:0]  nmode;
    logic [16:0] av;
    logic [31:0] rd;
    wr_en = w; addr = a; wdata = d;
    for (int n = 0; n < 10; n++) begin
      ie[n] = m_act[3*n]; rs[n] = m_act[3*n+1]; st[n] = m_act[3*n+2];
    end
    tk = m_run && (m_pc >= m_presc);
    for (int n = 0; n < 10; n++) hit[n] = tk && (m_cmp[n] == m_cnt);
    stp = |(hit & st);
    rld = |(hit & rs);
    npc = m_pc;
    if (m_run) begin
      if (!tk) npc = m_pc + 16'd1;
      else if (!stp) npc = '0;
    end
    ncnt = m_cnt; nup = m_up;
    if (tk && !stp) begin
      if (rld) begin
        ncnt = (m_mode == 2'd1) ? m_cmp[9] : 16'd0;
        nup  = 1'b1;
      end else begin
        av = f_adv(m_mode, m_cnt, m_cmp[9], m_up);
        ncnt = av[15:0]; nup = av[16];
      end
    end
    ncen = m_run; nmode = m_mode;
    if (w && a == 5'd0) begin ncen = d[0]; nmode = d[2:1]; nup = 1'b1; end
    if (stp) ncen = 1'b0;
    if (w && a == 5'd2) begin ncnt = d[15:0]; npc = '0; end
    nfl = m_flags;
    if (w && a == 5'd6) nfl = nfl & ~d[9:0];
    nfl = nfl | (hit & ie);
    rd = f_read(a);
    @(posedge clk);
    m_run = ncen; m_mode = nmode; m_pc = npc; m_cnt = ncnt; m_up = nup;
    m_flags = nfl; m_irq = |nfl; m_stat = hit; m_rd = rd;
    if (w && a == 5'd1) m_presc = d[15:0];
    if (w && a == 5'd4 && d[31:24] == 8'h5A) m_act[23:0] = d[23:0];
    if (w && a == 5'd5 && d[31:24] == 8'h5A) m_act[29:24] = d[5:0];
    if (w && a >= 5'd16 && a <= 5'd25) m_cmp[a - 5'd16] = d[15:0];
    @(negedge clk);
    chk("R7 run bit", {31'b0, run}, {31'b0, m_run});
    chk("R5 flags", {22'b0, irq_flags}, {22'b0, m_flags});
    chk("R5 irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R10 match pulse", {22'b0, match_stat}, {22'b0, m_stat});
    chk("R2 read data", rdata, m_rd);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(1'b1, 5'(a), d);
  endtask

  task automatic rd_idle(input int a);
    step(1'b0, 5'(a), 32'h0);
  endtask

  task automatic run_seq(input string tag, input logic [127:0] ex);
    for (int i = 0; i < 8; i++) begin
      rd_idle(A_COUNT);
      chk(tag, rdata, {16'b0, ex[127-16*i -: 16]});
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_run = 0; m_up = 1; m_irq = 0; m_mode = 0; m_presc = 0; m_pc = 0; m_cnt = 0;
    m_act = 0; m_flags = 0; m_stat = 0; m_rd = 0;
    for (int n = 0; n < 10; n++) m_cmp[n] = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 run", {31'b0, run}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 flags", {22'b0, irq_flags}, 32'h0);
    rd_idle(A_ACT_LO);
    chk("R1 action word", rdata, 32'h0);
    rd_idle(A_COUNT);
    chk("R1 counter", rdata, 32'h0);

    // R4: keyed writes
    wr(A_ACT_LO, 32'h0000_0007);
    rd_idle(A_ACT_LO);
    chk("R4 unkeyed write ignored", rdata, 32'h0);
    wr(A_ACT_LO, 32'h5A00_0007);
    rd_idle(A_ACT_LO);
    chk("R4 keyed write, key reads 0", rdata, 32'h0000_0007);
    wr(A_ACT_LO, 32'h5B00_0000);
    rd_idle(A_ACT_LO);
    chk("R4 wrong key ignored", rdata, 32'h0000_0007);

    // R3 / R7: halt on channel 9 (word 5, bit 5)
    wr(A_ACT_LO, 32'h5A00_0000);
    wr(A_ACT_HI, 32'h5A00_0020);
    wr(A_CMP_BASE + 9, 32'd4);
    wr(A_COUNT, 32'd0);
    wr(A_PRESCALE, 32'd0);
    wr(A_CTRL, 32'd1);
    repeat (8) rd_idle(A_CTRL);
    chk("R7 halt cleared run", {31'b0, run}, 32'h0);
    rd_idle(A_COUNT);
    chk("R3 R7 counter frozen at compare 9", rdata, 32'd4);
    // R11: idle keeps counter
    repeat (3) begin
      rd_idle(A_COUNT);
      chk("R11 counter held while stopped", rdata, 32'd4);
    end

    // R2: prescale 1 -> one step every two clocks
    wr(A_ACT_HI, 32'h5A00_0000);
    wr(A_COUNT, 32'd0);
    wr(A_PRESCALE, 32'd1);
    wr(A_CTRL, 32'd1);
    run_seq("R2 prescaled steps", {16'd0,16'd0,16'd1,16'd1,16'd2,16'd2,16'd3,16'd3});
    wr(A_CTRL, 32'd0);

    // R6 / R5: channel 0 restart + interrupt at 3
    wr(A_ACT_LO, 32'h5A00_0003);
    wr(A_CMP_BASE + 0, 32'd3);
    wr(A_COUNT, 32'd0);
    wr(A_PRESCALE, 32'd0);
    wr(A_CTRL, 32'd1);
    run_seq("R6 up restart", {16'd0,16'd1,16'd2,16'd3,16'd0,16'd1,16'd2,16'd3});
    chk("R5 flag 0 set", {22'b0, irq_flags}, 32'h1);
    chk("R5 irq high", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'd0);
    wr(A_FLAGS, 32'h0000_0001);
    chk("R5 write-1-clear", {22'b0, irq_flags}, 32'h0);
    chk("R5 irq low", {31'b0, irq}, 32'h0);

    // R8: down mode, restart reloads compare 9
    wr(A_ACT_LO, 32'h5A00_0002);
    wr(A_CMP_BASE + 0, 32'd1);
    wr(A_CMP_BASE + 9, 32'd3);
    wr(A_COUNT, 32'd2);
    wr(A_CTRL, 32'd3);
    run_seq("R8 down reload", {16'd2,16'd1,16'd3,16'd2,16'd1,16'd3,16'd2,16'd1});
    wr(A_CTRL, 32'd0);

    // R9 / R10: up-then-down between 0 and 3, channel 0 at 2 with no actions
    wr(A_ACT_LO, 32'h5A00_0000);
    wr(A_CMP_BASE + 0, 32'd2);
    wr(A_COUNT, 32'd0);
    wr(A_CTRL, 32'd5);
    run_seq("R9 center", {16'd0,16'd1,16'd2,16'd3,16'd2,16'd1,16'd0,16'd1});
    chk("R10 no flag without enable", {22'b0, irq_flags}, 32'h0);
    wr(A_CTRL, 32'd0);

    // mixed random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 78) begin
        int idx;
        idx = $urandom % 17;
        rd_idle(idx < 7 ? idx : 16 + idx - 7);
      end else begin
        int sel;
        logic [31:0] dd;
        sel = $urandom % 8;
        case (sel)
          0: wr(A_CTRL, {29'b0, 2'($urandom % 4), 1'(($urandom % 4) != 0)});
          1: wr(A_PRESCALE, $urandom % 4);
          2: wr(A_COUNT, $urandom % 24);
          3: begin
            dd = $urandom & $urandom & $urandom;
            dd[31:24] = ($urandom % 2) ? 8'h5A : 8'($urandom);
            wr(A_ACT_LO, dd);
          end
          4: begin
            dd = $urandom & $urandom;
            dd[31:24] = ($urandom % 2) ? 8'h5A : 8'($urandom);
            wr(A_ACT_HI, dd);
          end
          5: wr(A_FLAGS, $urandom);
          default: wr(A_CMP_BASE + ($urandom % 10), $urandom % 24);
        endcase
      end
    end

    summary();
    $finish;
  end
endmodule